// File: doc/BRIEF.md
# Rotating Priority Resolver

This block holds the in-service state and the rotating priority origin of one eight-line interrupt controller. Each cycle it takes a vector of pending requests and a mask vector from the surrounding controller. It decides whether the processor should be interrupted, and if so which line wins. The search for a winner starts at the current priority origin and wraps around. A request raises the interrupt only when it outranks every line that is already being serviced.

The host side delivers already-decoded work in two forms. One is an acknowledge strobe. The other is a command strobe that carries a 3-bit code and a 3-bit operand. These cover the end-of-interrupt variants (non-specific, specific, each with or without rotation), loading the priority origin directly, and setting or clearing rotation on automatic end-of-interrupt. An automatic end-of-interrupt input makes acknowledges leave the in-service register untouched. A nesting input, used on the primary instance of a cascaded pair, keeps the cascade line's in-service bit from blocking further requests.

Top module: `rot_prio_resolver`

## Requirements
- R1: A synchronous active-high reset clears the in-service register, the priority origin and the rotate-on-auto-EOI flag.
- R2: Pending lines are the request bits that are not masked. Line `prio_base` has rank 0, the line after it has rank 1, and so on modulo 8. The pending line with the lowest rank wins.
- R3: `irq_req` is high only when the winning pending line has a strictly lower rank than the lowest-ranked in-service line. An empty in-service register counts as rank 8. `irq_line` carries the winner while `irq_req` is high and reads 0 otherwise.
- R4: On the primary instance (parameter `PRIMARY`=1), setting `nested_sp` removes in-service bit `CASCADE` (default 2) from the rank comparison of R3.
- R5: An acknowledge taken while `irq_req` is high, with `auto_eoi` low, sets the winner's in-service bit. An acknowledge while `irq_req` is low changes nothing.
- R6: An acknowledge with `auto_eoi` high leaves the in-service register unchanged. If the rotate-on-auto-EOI flag is set, the priority origin becomes (winner+1) mod 8.
- R7: Command code 1 clears the lowest-ranked in-service bit. Code 5 does the same and also sets the origin to (that line+1) mod 8. With nothing in service, neither code changes any state.
- R8: Command code 3 clears the in-service bit selected by `cmd_arg`. Code 7 does the same and also sets the origin to (`cmd_arg`+1) mod 8.
- R9: Command code 6 sets the origin to (`cmd_arg`+1) mod 8 and leaves the in-service register unchanged.
- R10: Command code 4 sets and code 0 clears the rotate-on-auto-EOI flag. Code 2 changes nothing.
- R11: When an acknowledge and a command arrive in the same cycle, the acknowledge is applied first and the command acts on its result.
- R12: `in_service`, `prio_base`, `irq_req` and `irq_line` reflect a strobe only from the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_lines | input | N | Pending request per line |
| mask_lines | input | N | Mask per line, 1 blocks the line |
| ack_stb | input | 1 | Acknowledge strobe |
| cmd_stb | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (0..7) |
| cmd_arg | input | LW | Line operand of the command |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| nested_sp | input | 1 | Special nesting on the cascade line |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_line | output | LW | Winning line |
| in_service | output | N | In-service register |
| prio_base | output | LW | Line currently holding rank 0 |

## Verification
An acknowledge and a command can fall in the same cycle, and the order between them decides the result. The bench provokes this twice. In the first case an acknowledge comes together with a non-specific end-of-interrupt, so the bit just set is the one cleared and the in-service register ends empty. In the second case an acknowledge of line 7 comes together with a specific end-of-interrupt for line 0, which was already in service, so only bit 7 remains. Both results are judged at the in-service port one cycle after the strobes.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  typedef enum logic [2:0] {
    CMD_ROT_CLR    = 3'd0,
    CMD_EOI_NS     = 3'd1,
    CMD_NOP        = 3'd2,
    CMD_EOI_SP     = 3'd3,
    CMD_ROT_SET    = 3'd4,
    CMD_EOI_NS_ROT = 3'd5,
    CMD_SET_PRI    = 3'd6,
    CMD_EOI_SP_ROT = 3'd7
  } cmd_e;
endpackage

// File: rtl/rpr_search.sv
// Rotated find-first: returns the lowest-ranked set bit counted from base.
module rpr_search #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] base,
  output logic          found,
  output logic [LW:0]   rank,
  output logic [LW-1:0] line
);
  logic [N-1:0] rot;

  for (genvar g = 0; g < N; g++) begin : g_rot
    always_comb rot[g] = vec[(g + int'(base)) % N];
  end

  always_comb begin
    found = 1'b0;
    rank  = (LW+1)'(N);
    line  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) begin
        found = 1'b1;
        rank  = (LW+1)'(i);
        line  = LW'((i + int'(base)) % N);
      end
    end
  end
endmodule

// File: rtl/rpr_update.sv
// Next-state logic: acknowledge first, then the command on the result.
module rpr_update
  import rpr_pkg::*;
#(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  isr_q,
  input  logic [LW-1:0] base_q,
  input  logic          rot_q,
  input  logic          ack_go,
  input  logic          aeoi,
  input  logic [LW-1:0] win,
  input  logic          cmd_stb,
  input  logic [2:0]    cmd_code,
  input  logic [LW-1:0] cmd_arg,
  output logic [N-1:0]  isr_d,
  output logic [LW-1:0] base_d,
  output logic          rot_d
);
  function automatic logic [LW-1:0] nxt(input logic [LW-1:0] l);
    nxt = LW'((int'(l) + 1) % N);
  endfunction

  logic [N-1:0]  isr_a;
  logic [LW-1:0] base_a;
  logic          top_found;
  logic [LW:0]   top_rank;
  logic [LW-1:0] top_line;

  always_comb begin
    isr_a  = isr_q;
    base_a = base_q;
    if (ack_go) begin
      if (!aeoi)     isr_a[win] = 1'b1;
      else if (rot_q) base_a    = nxt(win);
    end
  end

  rpr_search #(.N(N)) i_top (
    .vec(isr_a), .base(base_a),
    .found(top_found), .rank(top_rank), .line(top_line)
  );

  always_comb begin
    isr_d  = isr_a;
    base_d = base_a;
    rot_d  = rot_q;
    if (cmd_stb) begin
      case (cmd_e'(cmd_code))
        CMD_ROT_CLR: rot_d = 1'b0;
        CMD_ROT_SET: rot_d = 1'b1;
        CMD_EOI_NS:  if (top_found) isr_d[top_line] = 1'b0;
        CMD_EOI_NS_ROT: if (top_found) begin
          isr_d[top_line] = 1'b0;
          base_d          = nxt(top_line);
        end
        CMD_EOI_SP:  isr_d[cmd_arg] = 1'b0;
        CMD_EOI_SP_ROT: begin
          isr_d[cmd_arg] = 1'b0;
          base_d         = nxt(cmd_arg);
        end
        CMD_SET_PRI: base_d = nxt(cmd_arg);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter int N       = 8,
  parameter bit PRIMARY = 1'b1,
  parameter int CASCADE = 2,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_lines,
  input  logic [N-1:0]  mask_lines,
  input  logic          ack_stb,
  input  logic          cmd_stb,
  input  logic [2:0]    cmd_code,
  input  logic [LW-1:0] cmd_arg,
  input  logic          auto_eoi,
  input  logic          nested_sp,
  output logic          irq_req,
  output logic [LW-1:0] irq_line,
  output logic [N-1:0]  in_service,
  output logic [LW-1:0] prio_base
);
  localparam logic [N-1:0] CASC_BIT = {{(N-1){1'b0}}, 1'b1} << CASCADE;

  logic [N-1:0]  isr_q, isr_d, cur_isr, pend;
  logic [LW-1:0] base_q, base_d;
  logic          rot_q, rot_d;
  logic          req_found, isr_found;
  logic [LW:0]   req_rank, isr_rank;
  logic [LW-1:0] req_line, isr_line;

  assign pend    = req_lines & ~mask_lines;
  assign cur_isr = isr_q & ~((nested_sp && PRIMARY) ? CASC_BIT : '0);

  rpr_search #(.N(N)) i_req (
    .vec(pend), .base(base_q),
    .found(req_found), .rank(req_rank), .line(req_line)
  );

  rpr_search #(.N(N)) i_cur (
    .vec(cur_isr), .base(base_q),
    .found(isr_found), .rank(isr_rank), .line(isr_line)
  );

  assign irq_req  = req_found && (req_rank < isr_rank);
  assign irq_line = irq_req ? req_line : '0;

  rpr_update #(.N(N)) i_upd (
    .isr_q(isr_q), .base_q(base_q), .rot_q(rot_q),
    .ack_go(ack_stb && irq_req), .aeoi(auto_eoi), .win(req_line),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
    .isr_d(isr_d), .base_d(base_d), .rot_d(rot_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      base_q <= '0;
      rot_q  <= 1'b0;
    end else begin
      isr_q  <= isr_d;
      base_q <= base_d;
      rot_q  <= rot_d;
    end
  end

  assign in_service = isr_q;
  assign prio_base  = base_q;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (in_service == '0 && prio_base == '0));

  // R3
  winner_pending_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (req_lines[irq_line] && !mask_lines[irq_line]));

  // R3
  winner_not_served_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !nested_sp) |-> !in_service[irq_line]);

  // R5
  ack_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && irq_req && !auto_eoi && !cmd_stb) |=> in_service[$past(irq_line)]);

  // R6
  aeoi_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && auto_eoi && !cmd_stb) |=> (in_service == $past(in_service)));

  // R9
  set_pri_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_code == CMD_SET_PRI && !ack_stb) |=>
      ((int'(prio_base) == (int'($past(cmd_arg)) + 1) % N) &&
       in_service == $past(in_service)));
endmodule

// File: tb/test_rot_prio_resolver.sv
module test_rot_prio_resolver;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]  req_lines = '0, mask_lines = '0;
  logic          ack_stb = 1'b0, cmd_stb = 1'b0;
  logic [2:0]    cmd_code = '0;
  logic [LW-1:0] cmd_arg = '0;
  logic          auto_eoi = 1'b0, nested_sp = 1'b0;
  logic          irq_req;
  logic [LW-1:0] irq_line;
  logic [N-1:0]  in_service;
  logic [LW-1:0] prio_base;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rot_prio_resolver i_rot_prio_resolver (
    .clk(clk), .rst(rst), .req_lines(req_lines), .mask_lines(mask_lines),
    .ack_stb(ack_stb), .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
    .auto_eoi(auto_eoi), .nested_sp(nested_sp), .irq_req(irq_req),
    .irq_line(irq_line), .in_service(in_service), .prio_base(prio_base)
  );

  // {req, mask, ack, cmd_stb, code, arg, aeoi, nested, exp_irq, exp_line, exp_isr, exp_base}
  localparam logic [40:0] VEC [NV] = '{
    {8'h00,8'h00,1'b0,1'b0,3'd0,3'd0,1'b0,1'b0, 1'b0,3'd0,8'h00,3'd0}, // R1 idle
    {8'h28,8'h00,1'b0,1'b0,3'd0,3'd0,1'b0,1'b0, 1'b1,3'd3,8'h00,3'd0}, // R2
    {8'h28,8'h08,1'b0,1'b0,3'd0,3'd0,1'b0,1'b0, 1'b1,3'd5,8'h00,3'd0}, // R2 mask
    {8'h28,8'h00,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0, 1'b0,3'd0,8'h08,3'd0}, // R5
    {8'h21,8'h00,1'b0,1'b0,3'd0,3'd0,1'b0,1'b0, 1'b1,3'd0,8'h08,3'd0}, // R3
    {8'h21,8'h00,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0, 1'b0,3'd0,8'h09,3'd0}, // R5
    {8'h20,8'h00,1'b0,1'b1,3'd1,3'd0,1'b0,1'b0, 1'b0,3'd0,8'h08,3'd0}, // R7
    {8'h20,8'h00,1'b0,1'b1,3'd3,3'd3,1'b0,1'b0, 1'b1,3'd5,8'h00,3'd0}, // R8
    {8'h21,8'h00,1'b0,1'b1,3'd6,3'd4,1'b0,1'b0, 1'b1,3'd5,8'h00,3'd5}, // R9
    {8'h21,8'h00,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0, 1'b0,3'd0,8'h20,3'd5}, // R5
    {8'h21,8'h00,1'b0,1'b1,3'd5,3'd0,1'b0,1'b0, 1'b1,3'd0,8'h00,3'd6}, // R7 rotate
    {8'h21,8'h00,1'b0,1'b1,3'd4,3'd0,1'b0,1'b0, 1'b1,3'd0,8'h00,3'd6}, // R10 set
    {8'h21,8'h00,1'b1,1'b0,3'd0,3'd0,1'b1,1'b0, 1'b1,3'd5,8'h00,3'd1}, // R6 rotate
    {8'h21,8'h00,1'b0,1'b1,3'd0,3'd0,1'b0,1'b0, 1'b1,3'd5,8'h00,3'd1}, // R10 clear
    {8'h21,8'h00,1'b1,1'b0,3'd0,3'd0,1'b1,1'b0, 1'b1,3'd5,8'h00,3'd1}, // R6 no rotate
    {8'h21,8'h00,1'b0,1'b1,3'd7,3'd6,1'b0,1'b0, 1'b1,3'd0,8'h00,3'd7}, // R8 rotate
    {8'h04,8'h00,1'b1,1'b0,3'd0,3'd0,1'b0,1'b0, 1'b0,3'd0,8'h04,3'd7}, // R5 line 2
    {8'h04,8'h00,1'b0,1'b0,3'd0,3'd0,1'b0,1'b1, 1'b1,3'd2,8'h04,3'd7}, // R4
    {8'h06,8'h00,1'b0,1'b0,3'd0,3'd0,1'b0,1'b1, 1'b1,3'd1,8'h04,3'd7}, // R4
    {8'h00,8'h00,1'b0,1'b1,3'd1,3'd0,1'b0,1'b0, 1'b0,3'd0,8'h00,3'd7}, // R7
    {8'h00,8'h00,1'b0,1'b1,3'd5,3'd0,1'b0,1'b0, 1'b0,3'd0,8'h00,3'd7}, // R7 empty
    {8'h00,8'h00,1'b0,1'b1,3'd2,3'd0,1'b0,1'b0, 1'b0,3'd0,8'h00,3'd7}  // R10 no-op
  };
  localparam string TAG [NV] = '{"R1","R2","R2","R5","R3","R5","R7","R8","R9","R5","R7",
                                 "R10","R6","R10","R6","R8","R5","R4","R4","R7","R7","R10"};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input bit e_irq, input int e_line,
                           input int e_isr, input int e_base);
    chk(tag, "irq_req", int'(irq_req), int'(e_irq));
    chk(tag, "irq_line", int'(irq_line), e_line);
    chk(tag, "in_service", int'(in_service), e_isr);
    chk(tag, "prio_base", int'(prio_base), e_base);
  endtask

  task automatic apply(input logic [7:0] rq, input logic [7:0] mk, input bit ak,
                       input bit cs, input logic [2:0] cd, input logic [2:0] ar,
                       input bit ae, input bit ns);
    @(negedge clk);
    req_lines = rq; mask_lines = mk; ack_stb = ak; cmd_stb = cs;
    cmd_code = cd; cmd_arg = ar; auto_eoi = ae; nested_sp = ns;
    @(negedge clk);
    ack_stb = 1'b0; cmd_stb = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check_all("R1", 1'b0, 0, 0, 0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][40:33], VEC[v][32:25], VEC[v][24], VEC[v][23], VEC[v][22:20],
            VEC[v][19:17], VEC[v][16], VEC[v][15]);
      check_all(TAG[v], VEC[v][14], int'(VEC[v][13:11]), int'(VEC[v][10:3]),
                int'(VEC[v][2:0]));
    end

    // R12: an acknowledge is not visible before the edge that takes it
    @(negedge clk);
    req_lines = 8'h01; ack_stb = 1'b1;
    #1;
    chk("R12", "in_service before edge", int'(in_service), 0);
    chk("R12", "irq_req before edge", int'(irq_req), 1);
    // R11: acknowledge plus non-specific EOI in one cycle
    cmd_stb = 1'b1; cmd_code = 3'd1;
    @(negedge clk);
    ack_stb = 1'b0; cmd_stb = 1'b0;
    #1;
    check_all("R11", 1'b1, 0, 8'h00, 7);

    apply(8'h01, 8'h00, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
    check_all("R5", 1'b0, 0, 8'h01, 7);
    // R11: acknowledge of line 7 plus specific EOI of line 0
    apply(8'h81, 8'h00, 1'b1, 1'b1, 3'd3, 3'd0, 1'b0, 1'b0);
    check_all("R11", 1'b0, 0, 8'h80, 7);
    // R5: acknowledge with no interrupt raised changes nothing
    apply(8'h00, 8'h00, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
    check_all("R5", 1'b0, 0, 8'h80, 7);

    // R1: reset mid-operation, rotate flag set beforehand
    apply(8'h00, 8'h00, 1'b0, 1'b1, 3'd4, 3'd0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check_all("R1", 1'b0, 0, 8'h00, 0);
    apply(8'h08, 8'h00, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0);
    check_all("R1", 1'b1, 3, 8'h00, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule